// File: doc/BRIEF.md
# Hardwired Timed Control-Signal Generator

This block is the hardwired control unit of a small accumulator machine built around one shared register bus. When an instruction has been loaded into the instruction register, a one-cycle start pulse hands its 4-bit opcode to the block. The block then walks a one-hot step ring, one step per clock. At each step it issues one control word: a 3-bit bus source code, a 3-bit bus destination code, a one-hot ALU function and a counter-clear strobe. The word is formed by ANDing a combinational opcode decode with the current step.

Every sequence ends with a step that raises only the counter-clear strobe. On the clock after that step the ring goes back to idle, where every output is low. The ring then waits there for the next start pulse. It never wraps round to the first step by itself. Bus codes: 0 main memory, 1 memory address register, 2 program counter, 3 memory buffer register, 4 accumulator, 7 instruction register. ALU lines: bit 0 add, bit 1 subtract, bit 2 clear, bit 3 pass (do nothing).

Top module: `ctl_seq_top`

## Requirements
- R1: After reset, and during any cycle in which reset is high, all outputs are zero. While idle with no start pulse they stay zero.
- R2: A start pulse sampled while idle makes `tstep` equal 8'b0000_0001 (first step) after the next rising edge. While busy, `tstep` is one-hot and moves up one bit per clock.
- R3: Add (opcode 4'b0011). Step 0: `rd_sel`=7, `wr_sel`=1, `alu_fn`=0. Step 1: `rd_sel`=0, `wr_sel`=3. Step 2: `rd_sel`=3, `wr_sel`=4, `alu_fn`=4'b0001. Step 3: `cnt_clr`=1 with the bus codes and ALU lines all zero.
- R4: Load (opcode 4'b0001) has the Add sequence except that step 2 carries `alu_fn`=4'b1000 (pass).
- R5: Subtract (opcode 4'b0100) has the Add sequence except that step 2 carries `alu_fn`=4'b0010.
- R6: Any other opcode gives a step 0 with `cnt_clr`=1 and the bus codes and ALU lines zero. The clock after that step is idle.
- R7: On the clock after a cycle with `cnt_clr` high, all outputs are zero (idle).
- R8: The opcode is taken only with an accepted start. A start pulse, or a change of opcode, while a sequence is running (including its clear step) has no effect on that sequence, and the block is idle afterwards.
- R9: `alu_fn` has at most one bit high, and it is non-zero only during step 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: instruction register holds a new opcode |
| opcode | input | 4 | Opcode field of the instruction register |
| rd_sel | output | 3 | Bus source code |
| wr_sel | output | 3 | Bus destination code |
| alu_fn | output | 4 | One-hot ALU function (add, subtract, clear, pass) |
| tstep | output | 8 | One-hot current step, zero when idle |
| cnt_clr | output | 1 | Counter-clear strobe ending the sequence |

## Verification
A corrupt step ring shows on `tstep` in the same cycle as a lost, doubled or stuck bit. It also shows within one clock as bus codes that belong to the wrong step. A wrongly latched or decoded opcode first appears at step 0 of the sequence. An undefined opcode at that step gives a lone `cnt_clr`, while a defined one gives the instruction-register-to-address-register transfer. A wrong opcode class that is still a defined one is exposed only two clocks later, in the step 2 ALU line. A missing clear is seen one clock after the last step, when `tstep` fails to return to zero.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  localparam int SEL_W = 3;
  localparam int OP_W  = 4;
  localparam int ALU_N = 4;

  // shared bus endpoint codes
  localparam logic [SEL_W-1:0] BUS_MEM = 3'd0;
  localparam logic [SEL_W-1:0] BUS_MAR = 3'd1;
  localparam logic [SEL_W-1:0] BUS_PC  = 3'd2;
  localparam logic [SEL_W-1:0] BUS_MBR = 3'd3;
  localparam logic [SEL_W-1:0] BUS_AC  = 3'd4;
  localparam logic [SEL_W-1:0] BUS_IR  = 3'd7;

  // ALU line positions
  localparam int ALU_ADD = 0;
  localparam int ALU_SUB = 1;
  localparam int ALU_CLR = 2;
  localparam int ALU_NOP = 3;

  localparam logic [OP_W-1:0] OPC_LOAD = 4'h1;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'h3;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'h4;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_LOAD,
    CLS_ADD,
    CLS_SUB
  } op_cls_t;

  typedef struct packed {
    logic [SEL_W-1:0] rd;
    logic [SEL_W-1:0] wr;
    logic [ALU_N-1:0] alu;
    logic             clr;
  } ctl_word_t;

endpackage

// File: rtl/ctl_op_decode.sv
module ctl_op_decode
  import ctl_seq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_cls_t         cls
);

  always_comb begin
    unique case (op)
      OPC_LOAD: cls = CLS_LOAD;
      OPC_ADD:  cls = CLS_ADD;
      OPC_SUB:  cls = CLS_SUB;
      default:  cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/ctl_step_ring.sv
module ctl_step_ring #(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             clr_q,
  output logic             accept,
  output logic [STEPS-1:0] t_nxt,
  output logic [STEPS-1:0] t_q
);

  localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

  logic idle;
  assign idle   = (t_q == '0);
  assign accept = idle && start;

  // one-hot ring: restarts only through the clear step, never wraps
  always_comb begin
    if (clr_q)
      t_nxt = '0;
    else if (idle)
      t_nxt = accept ? FIRST : '0;
    else
      t_nxt = t_q << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) t_q <= '0;
    else     t_q <= t_nxt;
  end

endmodule

// File: rtl/ctl_signal_matrix.sv
module ctl_signal_matrix
  import ctl_seq_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic [STEPS-1:0] t,
  input  op_cls_t          cls,
  output ctl_word_t        w
);

  logic defined;
  logic late;
  logic [ALU_N-1:0] alu_pick;

  assign defined = (cls != CLS_NONE);
  // steps beyond the last defined one force a clear (runaway guard)
  assign late = |t[STEPS-1:4];

  always_comb begin
    alu_pick = '0;
    unique case (cls)
      CLS_ADD:  alu_pick[ALU_ADD] = 1'b1;
      CLS_SUB:  alu_pick[ALU_SUB] = 1'b1;
      CLS_LOAD: alu_pick[ALU_NOP] = 1'b1;
      default:  alu_pick = '0;
    endcase
  end

  always_comb begin
    w = '0;
    if (t[0] && defined) begin
      w.rd = BUS_IR;
      w.wr = BUS_MAR;
    end
    if (t[1] && defined) begin
      w.rd = BUS_MEM;
      w.wr = BUS_MBR;
    end
    if (t[2] && defined) begin
      w.rd  = BUS_MBR;
      w.wr  = BUS_AC;
      w.alu = alu_pick;
    end
    w.clr = (t[0] && !defined) || t[3] || late;
  end

endmodule

// File: rtl/ctl_seq_top.sv
module ctl_seq_top
  import ctl_seq_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       opcode,
  output logic [2:0]       rd_sel,
  output logic [2:0]       wr_sel,
  output logic [3:0]       alu_fn,
  output logic [STEPS-1:0] tstep,
  output logic             cnt_clr
);

  logic             accept;
  logic [STEPS-1:0] t_nxt;
  logic [STEPS-1:0] t_q;
  logic [OP_W-1:0]  op_q;
  logic [OP_W-1:0]  op_nxt;
  op_cls_t          cls_nxt;
  ctl_word_t        w_nxt;
  ctl_word_t        w_q;

  ctl_step_ring #(.STEPS(STEPS)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .clr_q  (w_q.clr),
    .accept (accept),
    .t_nxt  (t_nxt),
    .t_q    (t_q)
  );

  // opcode is captured only with an accepted start
  assign op_nxt = accept ? opcode : op_q;

  always_ff @(posedge clk) begin
    if (rst) op_q <= '0;
    else     op_q <= op_nxt;
  end

  ctl_op_decode u_dec (
    .op  (op_nxt),
    .cls (cls_nxt)
  );

  // decode the next step so that the control word leaves a register
  ctl_signal_matrix #(.STEPS(STEPS)) u_mat (
    .t   (t_nxt),
    .cls (cls_nxt),
    .w   (w_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) w_q <= '0;
    else     w_q <= w_nxt;
  end

  assign rd_sel  = w_q.rd;
  assign wr_sel  = w_q.wr;
  assign alu_fn  = w_q.alu;
  assign cnt_clr = w_q.clr;
  assign tstep   = t_q;

endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk #(
  parameter int STEPS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [2:0]       rd_sel,
  input logic [2:0]       wr_sel,
  input logic [3:0]       alu_fn,
  input logic [STEPS-1:0] tstep,
  input logic             cnt_clr
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (tstep == '0) |-> (rd_sel == '0 && wr_sel == '0 && alu_fn == '0 && !cnt_clr));

  p_ring_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tstep));

  p_start_first_r2: assert property (@(posedge clk) disable iff (rst)
    (tstep == '0 && start) |=> (tstep == {{(STEPS-1){1'b0}}, 1'b1}));

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (tstep != '0 && !cnt_clr && !tstep[STEPS-1]) |=> (tstep == ($past(tstep) << 1)));

  p_clr_idle_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (tstep == '0));

  p_alu_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alu_fn));

  p_alu_step2_r9: assert property (@(posedge clk) disable iff (rst)
    (alu_fn != '0) |-> tstep[2]);

  p_clr_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |-> (rd_sel == '0 && wr_sel == '0 && alu_fn == '0));

endmodule

bind ctl_seq_top ctl_seq_chk #(.STEPS(STEPS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .rd_sel  (rd_sel),
  .wr_sel  (wr_sel),
  .alu_fn  (alu_fn),
  .tstep   (tstep),
  .cnt_clr (cnt_clr)
);

// File: tb/ctl_seq_top_test.sv
`timescale 1ns/1ps
module ctl_seq_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic [2:0] rd_sel;
  logic [2:0] wr_sel;
  logic [3:0] alu_fn;
  logic [7:0] tstep;
  logic       cnt_clr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ctl_seq_top uut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .opcode  (opcode),
    .rd_sel  (rd_sel),
    .wr_sel  (wr_sel),
    .alu_fn  (alu_fn),
    .tstep   (tstep),
    .cnt_clr (cnt_clr)
  );

  // packed view {tstep, rd, wr, alu, clr}
  function automatic logic [18:0] observed();
    return {tstep, rd_sel, wr_sel, alu_fn, cnt_clr};
  endfunction

  function automatic bit is_defined(input logic [3:0] op);
    return (op == 4'h1 || op == 4'h3 || op == 4'h4);
  endfunction

  function automatic logic [18:0] expect_step(input logic [3:0] op, input int s);
    logic [7:0] t;
    logic [2:0] rd;
    logic [2:0] wr;
    logic [3:0] alu;
    logic       clr;
    t = 8'b1 << s;
    rd = 3'd0; wr = 3'd0; alu = 4'd0; clr = 1'b0;
    if (!is_defined(op)) begin
      clr = 1'b1;
    end else begin
      case (s)
        0: begin rd = 3'd7; wr = 3'd1; end
        1: begin rd = 3'd0; wr = 3'd3; end
        2: begin
          rd = 3'd3; wr = 3'd4;
          alu = (op == 4'h3) ? 4'b0001 : (op == 4'h4) ? 4'b0010 : 4'b1000;
        end
        default: clr = 1'b1;
      endcase
    end
    return {t, rd, wr, alu, clr};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got t=%b rd=%0d wr=%0d alu=%b clr=%b, expected t=%b rd=%0d wr=%0d alu=%b clr=%b",
               tag, act[18:11], act[10:8], act[7:5], act[4:1], act[0],
               exp[18:11], exp[10:8], exp[7:5], exp[4:1], exp[0]);
    end
  endtask

  // one sequence; optional start/opcode disturbance while busy (R8)
  task automatic run_seq(input string tag, input logic [3:0] op,
                         input bit poke, input logic [3:0] poke_op);
    int last;
    last = is_defined(op) ? 3 : 0;
    @(negedge clk);
    start  = 1'b1;
    opcode = op;
    for (int s = 0; s <= last; s++) begin
      @(negedge clk);
      start = 1'b0;
      check(tag, observed(), expect_step(op, s));
      if (poke && (s == 1 || s == last)) begin
        start  = 1'b1;
        opcode = poke_op;
      end
    end
    @(negedge clk);
    start = 1'b0;
    check({tag, " R7 idle after clear"}, observed(), 19'd0);
    @(negedge clk);
    check({tag, " R8 no restart"}, observed(), 19'd0);
  endtask

  task automatic t_reset_idle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 idle after reset", observed(), 19'd0);
    end
  endtask

  task automatic t_add();      run_seq("R3 add", 4'h3, 1'b0, 4'h0); endtask
  task automatic t_load();     run_seq("R4 load", 4'h1, 1'b0, 4'h0); endtask
  task automatic t_sub();      run_seq("R5 subtract", 4'h4, 1'b0, 4'h0); endtask

  task automatic t_undef();
    run_seq("R6 undefined 0", 4'h0, 1'b0, 4'h0);
    run_seq("R6 undefined 2", 4'h2, 1'b0, 4'h0);
    run_seq("R6 undefined F", 4'hF, 1'b0, 4'h0);
  endtask

  task automatic t_busy_ignore();
    run_seq("R8 add disturbed", 4'h3, 1'b1, 4'h4);
    run_seq("R8 undefined disturbed", 4'h9, 1'b1, 4'h3);
  endtask

  task automatic t_back_to_back();
    // R2: a fresh start right after idle is accepted again
    run_seq("R2 first", 4'h1, 1'b0, 4'h0);
    run_seq("R2 second", 4'h4, 1'b0, 4'h0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    start = 1'b1; opcode = 4'h3;
    @(negedge clk);
    start = 1'b0;
    check("R2 first step before reset", observed(), expect_step(4'h3, 0));
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-sequence", observed(), 19'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after mid reset", observed(), 19'd0);
    run_seq("R3 add after reset", 4'h3, 1'b0, 4'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", observed(), 19'd0);
    rst = 1'b0;
    t_reset_idle();
    t_add();
    t_load();
    t_sub();
    t_undef();
    t_busy_ignore();
    t_back_to_back();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule